// File: doc/BRIEF.md
# Dual-Width Effective Address Generator

This block forms the offset part of a memory operand address for a segmented processor that can address memory with either 16-bit or 32-bit offsets. Each request carries the operating mode (real or protected), the default-size bit of the current code segment, and a per-instruction address-size override. From these the block picks the address size used for that one instruction. It then adds the chosen base register, the scaled index register and the displacement at that width.

The block also checks each request for register and scale choices that the chosen width does not allow. In real mode it raises a protection fault when a 32-bit computation lands above the 64 KB offset limit. A request strobe starts a computation. Exactly one of three result strobes follows on the next clock: a good address, an illegal encoding, or a protection fault. Segment base addition, paging, decoding and register reads happen elsewhere.

Top module: `eff_addr_unit`

## Requirements
- R1: The address size is 32-bit when (real_mode_i ? 0 : cs_dflt32_i) XOR asize_ovr_i is 1, otherwise 16-bit; asize32_o reports it for every request.
- R2: In 16-bit size the address is (base + index + displacement) modulo 2^16, zero-extended to 32 bits on ea_o.
- R3: In 32-bit size the address is (base + (index << scale_i) + displacement) modulo 2^32; an operand whose valid flag is low contributes zero.
- R4: disp_sz_i selects the displacement: 0 gives none, 1 gives disp_i[7:0] sign-extended to the active width, 2 gives the full active width of disp_i (low 16 bits in 16-bit size), and 3 is reserved and flags an illegal encoding.
- R5: Register identifiers are 0 AX, 1 CX, 2 DX, 3 BX, 4 SP, 5 BP, 6 SI, 7 DI. In 16-bit size a valid base must be 3 or 5 and a valid index must be 6 or 7, or the request is illegal; identifiers of operands marked not valid are ignored.
- R6: In 16-bit size a nonzero scale_i makes the request illegal; in 32-bit size scale_i 0..3 multiplies the index by 1, 2, 4 or 8.
- R7: A valid index with identifier 4 (SP) is illegal at either size; in 32-bit size any identifier, including 4, is accepted as base.
- R8: In real mode a 32-bit-size result above 0xFFFF raises gp_fault_o instead of addr_vld_o; a result of exactly 0xFFFF is a good address.
- R9: One clock after req_i exactly one of addr_vld_o, illegal_o, gp_fault_o pulses for one cycle, illegal taking priority over the limit fault; with no request none of them is high.
- R10: While rst_n is low all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe |
| real_mode_i | input | 1 | 1 in real mode, 0 in protected mode |
| cs_dflt32_i | input | 1 | Code segment default-size bit |
| asize_ovr_i | input | 1 | Address-size override for this instruction |
| base_vld_i | input | 1 | Base operand present |
| base_id_i | input | 3 | Base register identifier |
| base_val_i | input | 32 | Base register value |
| idx_vld_i | input | 1 | Index operand present |
| idx_id_i | input | 3 | Index register identifier |
| idx_val_i | input | 32 | Index register value |
| scale_i | input | 2 | Index shift amount |
| disp_i | input | 32 | Displacement, sign-extended |
| disp_sz_i | input | 2 | Displacement width code |
| ea_o | output | 32 | Effective address |
| asize32_o | output | 1 | Resolved size, 1 for 32-bit |
| addr_vld_o | output | 1 | Good address strobe |
| illegal_o | output | 1 | Illegal encoding strobe |
| gp_fault_o | output | 1 | Real-mode limit fault strobe |

## Verification
The bench targets the size-selection corners. These are an override inside real mode and an override that narrows a 32-bit segment; a design that ignored either would wrap or fail to wrap at 64 KB. It drives negative byte displacements in both widths and full displacements whose upper half must be dropped in 16-bit size, which catch a missing or wrong-width sign extension. It probes the real-mode limit at exactly 0xFFFF and 0x10000, where an off-by-one comparison would fault a good address or pass a bad one. It also presents an SP index together with an over-limit sum, where a design with the wrong priority would raise two strobes or the wrong one.

// File: rtl/ea_pkg.sv
package ea_pkg;
   localparam int REG_ID_W = 3;

   typedef enum logic [1:0] {
      DISP_NONE = 2'd0,
      DISP_BYTE = 2'd1,
      DISP_FULL = 2'd2,
      DISP_RSVD = 2'd3
   } disp_sz_e;

   localparam logic [REG_ID_W-1:0] ID_BX = 3'd3;
   localparam logic [REG_ID_W-1:0] ID_SP = 3'd4;
   localparam logic [REG_ID_W-1:0] ID_BP = 3'd5;
   localparam logic [REG_ID_W-1:0] ID_SI = 3'd6;
   localparam logic [REG_ID_W-1:0] ID_DI = 3'd7;
endpackage

// File: rtl/ea_size_sel.sv
module ea_size_sel (
   input  logic real_mode,
   input  logic cs_dflt32,
   input  logic ovr,
   output logic wide
);
   logic dflt_wide;
   assign dflt_wide = real_mode ? 1'b0 : cs_dflt32;
   assign wide      = dflt_wide ^ ovr;
endmodule

// File: rtl/ea_legal_chk.sv
module ea_legal_chk
   import ea_pkg::*;
#(
   parameter int SCALE_W = 2
) (
   input  logic                wide,
   input  logic                base_vld,
   input  logic [REG_ID_W-1:0] base_id,
   input  logic                idx_vld,
   input  logic [REG_ID_W-1:0] idx_id,
   input  logic [SCALE_W-1:0]  scale,
   input  disp_sz_e            dsz,
   output logic                illegal
);
   logic base_ok_n, idx_ok_n, sp_idx, scale_bad, disp_bad;

   assign base_ok_n = (base_id == ID_BX) || (base_id == ID_BP);
   assign idx_ok_n  = (idx_id == ID_SI) || (idx_id == ID_DI);
   assign sp_idx    = idx_vld && (idx_id == ID_SP);
   assign scale_bad = !wide && (scale != '0);
   assign disp_bad  = (dsz == DISP_RSVD);

   always_comb begin
      illegal = sp_idx || scale_bad || disp_bad;
      if (!wide) begin
         if (base_vld && !base_ok_n) illegal = 1'b1;
         if (idx_vld && !idx_ok_n)   illegal = 1'b1;
      end
   end
endmodule

// File: rtl/ea_sum.sv
module ea_sum
   import ea_pkg::*;
#(
   parameter int AW      = 32,
   parameter int NW      = 16,
   parameter int SCALE_W = 2
) (
   input  logic               wide,
   input  logic               base_vld,
   input  logic [AW-1:0]      base_val,
   input  logic               idx_vld,
   input  logic [AW-1:0]      idx_val,
   input  logic [SCALE_W-1:0] scale,
   input  logic [AW-1:0]      disp,
   input  disp_sz_e           dsz,
   output logic [AW-1:0]      sum,
   output logic               over_lim
);
   localparam int NLANE = 2;

   logic [AW-1:0] lane_sum [NLANE];

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      localparam int W = (g == 0) ? NW : AW;
      logic [W-1:0] b_op, i_op, d_op, s;

      assign b_op = base_vld ? base_val[W-1:0] : '0;
      assign i_op = idx_vld ? (idx_val[W-1:0] << scale) : '0;

      always_comb begin
         case (dsz)
            DISP_BYTE: d_op = {{(W-8){disp[7]}}, disp[7:0]};
            DISP_FULL: d_op = disp[W-1:0];
            default:   d_op = '0;
         endcase
      end

      assign s           = b_op + i_op + d_op;
      assign lane_sum[g] = AW'(s);
   end

   assign sum      = wide ? lane_sum[1] : lane_sum[0];
   assign over_lim = wide && (|lane_sum[1][AW-1:NW]);
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
   import ea_pkg::*;
#(
   parameter int AW      = 32,
   parameter int NW      = 16,
   parameter int SCALE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_i,
   input  logic               real_mode_i,
   input  logic               cs_dflt32_i,
   input  logic               asize_ovr_i,
   input  logic               base_vld_i,
   input  logic [2:0]         base_id_i,
   input  logic [AW-1:0]      base_val_i,
   input  logic               idx_vld_i,
   input  logic [2:0]         idx_id_i,
   input  logic [AW-1:0]      idx_val_i,
   input  logic [SCALE_W-1:0] scale_i,
   input  logic [AW-1:0]      disp_i,
   input  logic [1:0]         disp_sz_i,
   output logic [AW-1:0]      ea_o,
   output logic               asize32_o,
   output logic               addr_vld_o,
   output logic               illegal_o,
   output logic               gp_fault_o
);
   if (NW < 8 || AW <= NW) begin : g_bad_width
      $error("eff_addr_unit: need 8 <= NW < AW");
   end
   if (SCALE_W < 1 || SCALE_W > 3) begin : g_bad_scale
      $error("eff_addr_unit: SCALE_W out of range");
   end

   disp_sz_e      dsz;
   logic          wide, illegal, over_lim;
   logic [AW-1:0] sum;

   assign dsz = disp_sz_e'(disp_sz_i);

   ea_size_sel u_size (
      .real_mode (real_mode_i),
      .cs_dflt32 (cs_dflt32_i),
      .ovr       (asize_ovr_i),
      .wide      (wide)
   );

   ea_legal_chk #(.SCALE_W(SCALE_W)) u_legal (
      .wide     (wide),
      .base_vld (base_vld_i),
      .base_id  (base_id_i),
      .idx_vld  (idx_vld_i),
      .idx_id   (idx_id_i),
      .scale    (scale_i),
      .dsz      (dsz),
      .illegal  (illegal)
   );

   ea_sum #(.AW(AW), .NW(NW), .SCALE_W(SCALE_W)) u_sum (
      .wide     (wide),
      .base_vld (base_vld_i),
      .base_val (base_val_i),
      .idx_vld  (idx_vld_i),
      .idx_val  (idx_val_i),
      .scale    (scale_i),
      .disp     (disp_i),
      .dsz      (dsz),
      .sum      (sum),
      .over_lim (over_lim)
   );

   logic limit_hit;
   assign limit_hit = real_mode_i && over_lim;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ea_o       <= '0;
         asize32_o  <= 1'b0;
         addr_vld_o <= 1'b0;
         illegal_o  <= 1'b0;
         gp_fault_o <= 1'b0;
      end else begin
         addr_vld_o <= req_i && !illegal && !limit_hit;
         illegal_o  <= req_i && illegal;
         gp_fault_o <= req_i && !illegal && limit_hit;
         if (req_i) begin
            ea_o      <= sum;
            asize32_o <= wide;
         end
      end
   end
endmodule

// File: rtl/eff_addr_unit_chk.sv
module eff_addr_unit_chk #(
   parameter int AW      = 32,
   parameter int NW      = 16,
   parameter int SCALE_W = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_i,
   input logic               real_mode_i,
   input logic               cs_dflt32_i,
   input logic               asize_ovr_i,
   input logic               idx_vld_i,
   input logic [2:0]         idx_id_i,
   input logic [SCALE_W-1:0] scale_i,
   input logic [AW-1:0]      ea_o,
   input logic               asize32_o,
   input logic               addr_vld_o,
   input logic               illegal_o,
   input logic               gp_fault_o
);
   assert_reset_clear_R10: assert property (@(posedge clk)
      !rst_n |=> (!addr_vld_o && !illegal_o && !gp_fault_o && ea_o == '0));

   assert_strobe_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld_o || illegal_o || gp_fault_o) |-> $past(req_i));

   assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({addr_vld_o, illegal_o, gp_fault_o}));

   assert_req_gets_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> (addr_vld_o || illegal_o || gp_fault_o));

   assert_real_narrow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && real_mode_i && !asize_ovr_i) |=> !asize32_o);

   assert_prot_wide_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !real_mode_i && cs_dflt32_i && !asize_ovr_i) |=> asize32_o);

   assert_narrow_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld_o && !asize32_o) |-> (ea_o[AW-1:NW] == '0));

   assert_narrow_scale_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && real_mode_i && !asize_ovr_i && scale_i != '0) |=> illegal_o);

   assert_sp_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && idx_vld_i && idx_id_i == 3'd4) |=> illegal_o);

   assert_fault_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      gp_fault_o |-> ($past(real_mode_i) && asize32_o && ea_o[AW-1:NW] != '0));
endmodule

bind eff_addr_unit eff_addr_unit_chk #(.AW(AW), .NW(NW), .SCALE_W(SCALE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_i       (req_i),
   .real_mode_i (real_mode_i),
   .cs_dflt32_i (cs_dflt32_i),
   .asize_ovr_i (asize_ovr_i),
   .idx_vld_i   (idx_vld_i),
   .idx_id_i    (idx_id_i),
   .scale_i     (scale_i),
   .ea_o        (ea_o),
   .asize32_o   (asize32_o),
   .addr_vld_o  (addr_vld_o),
   .illegal_o   (illegal_o),
   .gp_fault_o  (gp_fault_o)
);

// File: tb/test_eff_addr_unit.sv
module test_eff_addr_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic        real_mode_i = 1'b0, cs_dflt32_i = 1'b0, asize_ovr_i = 1'b0;
   logic        base_vld_i = 1'b0, idx_vld_i = 1'b0;
   logic [2:0]  base_id_i = '0, idx_id_i = '0;
   logic [31:0] base_val_i = '0, idx_val_i = '0, disp_i = '0;
   logic [1:0]  scale_i = '0, disp_sz_i = '0;
   logic [31:0] ea_o;
   logic        asize32_o, addr_vld_o, illegal_o, gp_fault_o;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   eff_addr_unit i_eff_addr_unit (
      .clk, .rst_n, .req_i, .real_mode_i, .cs_dflt32_i, .asize_ovr_i,
      .base_vld_i, .base_id_i, .base_val_i, .idx_vld_i, .idx_id_i, .idx_val_i,
      .scale_i, .disp_i, .disp_sz_i, .ea_o, .asize32_o, .addr_vld_o,
      .illegal_o, .gp_fault_o
   );

   // kind: 0 good address, 1 illegal, 2 limit fault
   typedef struct packed {
      logic [3:0]  tg;
      logic        rl, df, ov;
      logic        bv;
      logic [2:0]  bid;
      logic [31:0] bval;
      logic        iv;
      logic [2:0]  iid;
      logic [31:0] ival;
      logic [1:0]  sc;
      logic [31:0] disp;
      logic [1:0]  dsz;
      logic [31:0] e_ea;
      logic        e_a32;
      logic [1:0]  e_k;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VT [NV] = '{
      '{4'd3, 1'b0,1'b1,1'b0, 1'b1,3'd0,32'h1000_0000, 1'b1,3'd1,32'h10, 2'd3, 32'h100, 2'd2, 32'h1000_0180, 1'b1, 2'd0}, // R3 scaled
      '{4'd2, 1'b0,1'b0,1'b0, 1'b1,3'd3,32'h0001_FFF0, 1'b1,3'd6,32'h20, 2'd0, 32'h5, 2'd2, 32'h15, 1'b0, 2'd0},          // R2 wrap
      '{4'd4, 1'b1,1'b0,1'b0, 1'b1,3'd5,32'h10, 1'b0,3'd0,32'h0, 2'd0, 32'hFFFF_FF80, 2'd1, 32'hFF90, 1'b0, 2'd0},         // R4 neg byte narrow
      '{4'd4, 1'b0,1'b1,1'b0, 1'b1,3'd2,32'h100, 1'b0,3'd0,32'h0, 2'd0, 32'hFF, 2'd1, 32'hFF, 1'b1, 2'd0},                // R4 byte wide
      '{4'd4, 1'b0,1'b1,1'b0, 1'b1,3'd6,32'h1234, 1'b0,3'd0,32'h0, 2'd0, 32'hDEAD_BEEF, 2'd0, 32'h1234, 1'b1, 2'd0},      // R4 none
      '{4'd4, 1'b0,1'b0,1'b0, 1'b1,3'd3,32'h10, 1'b0,3'd0,32'h0, 2'd0, 32'h0001_0002, 2'd2, 32'h12, 1'b0, 2'd0},          // R4 full narrow
      '{4'd4, 1'b0,1'b1,1'b0, 1'b1,3'd0,32'h0, 1'b0,3'd0,32'h0, 2'd0, 32'h0, 2'd3, 32'h0, 1'b1, 2'd1},                    // R4 reserved
      '{4'd1, 1'b1,1'b0,1'b1, 1'b1,3'd3,32'h100, 1'b1,3'd7,32'h10, 2'd2, 32'h0, 2'd0, 32'h140, 1'b1, 2'd0},               // R1 real + override
      '{4'd8, 1'b1,1'b0,1'b1, 1'b1,3'd0,32'hFFFF, 1'b0,3'd0,32'h0, 2'd0, 32'h1, 2'd1, 32'h1_0000, 1'b1, 2'd2},            // R8 over limit
      '{4'd8, 1'b1,1'b0,1'b1, 1'b1,3'd0,32'hFFFE, 1'b0,3'd0,32'h0, 2'd0, 32'h1, 2'd1, 32'hFFFF, 1'b1, 2'd0},              // R8 at limit
      '{4'd1, 1'b0,1'b1,1'b1, 1'b1,3'd5,32'h8000, 1'b1,3'd7,32'h8000, 2'd0, 32'h0, 2'd0, 32'h0, 1'b0, 2'd0},              // R1 narrowing
      '{4'd5, 1'b0,1'b0,1'b0, 1'b1,3'd0,32'h10, 1'b0,3'd0,32'h0, 2'd0, 32'h0, 2'd0, 32'h0, 1'b0, 2'd1},                   // R5 base AX
      '{4'd5, 1'b0,1'b0,1'b0, 1'b1,3'd3,32'h0, 1'b1,3'd3,32'h0, 2'd0, 32'h0, 2'd0, 32'h0, 1'b0, 2'd1},                    // R5 index BX
      '{4'd6, 1'b0,1'b0,1'b0, 1'b1,3'd3,32'h0, 1'b1,3'd6,32'h4, 2'd1, 32'h0, 2'd0, 32'h0, 1'b0, 2'd1},                    // R6 narrow scale
      '{4'd7, 1'b0,1'b1,1'b0, 1'b1,3'd0,32'h0, 1'b1,3'd4,32'h4, 2'd0, 32'h0, 2'd0, 32'h0, 1'b1, 2'd1},                    // R7 SP index wide
      '{4'd7, 1'b0,1'b1,1'b0, 1'b1,3'd4,32'h2000, 1'b1,3'd5,32'h3, 2'd1, 32'h0, 2'd0, 32'h2006, 1'b1, 2'd0},              // R7 SP base wide
      '{4'd7, 1'b1,1'b0,1'b0, 1'b1,3'd3,32'h0, 1'b1,3'd4,32'h0, 2'd0, 32'h0, 2'd0, 32'h0, 1'b0, 2'd1},                    // R7 SP index narrow
      '{4'd3, 1'b0,1'b1,1'b0, 1'b1,3'd0,32'hFFFF_FFF0, 1'b0,3'd0,32'h0, 2'd0, 32'h20, 2'd2, 32'h10, 1'b1, 2'd0},          // R3 wrap
      '{4'd5, 1'b1,1'b0,1'b0, 1'b1,3'd3,32'h7, 1'b0,3'd0,32'h55, 2'd0, 32'h0, 2'd0, 32'h7, 1'b0, 2'd0},                   // R5 absent index ignored
      '{4'd9, 1'b1,1'b0,1'b1, 1'b1,3'd0,32'hF_FFFF, 1'b1,3'd4,32'h0, 2'd0, 32'h0, 2'd0, 32'h0, 1'b1, 2'd1},               // R9 illegal beats fault
      '{4'd3, 1'b0,1'b1,1'b0, 1'b0,3'd0,32'h999, 1'b1,3'd2,32'h8, 2'd2, 32'h0, 2'd0, 32'h20, 1'b1, 2'd0}                  // R3 absent base
   };

   task automatic chk(input bit ok, input int r, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", r, what, act, exp);
      end
   endtask

   function automatic logic [1:0] kind_now();
      if (addr_vld_o && !illegal_o && !gp_fault_o) return 2'd0;
      if (illegal_o && !addr_vld_o && !gp_fault_o) return 2'd1;
      if (gp_fault_o && !addr_vld_o && !illegal_o) return 2'd2;
      return 2'd3;
   endfunction

   task automatic apply(input vec_t v);
      real_mode_i = v.rl; cs_dflt32_i = v.df; asize_ovr_i = v.ov;
      base_vld_i = v.bv; base_id_i = v.bid; base_val_i = v.bval;
      idx_vld_i = v.iv; idx_id_i = v.iid; idx_val_i = v.ival;
      scale_i = v.sc; disp_i = v.disp; disp_sz_i = v.dsz;
   endtask

   task automatic check_vec(input vec_t v);
      chk(kind_now() == v.e_k, int'(v.tg), "strobe kind", 32'(kind_now()), 32'(v.e_k));
      chk(asize32_o == v.e_a32, int'(v.tg), "size", 32'(asize32_o), 32'(v.e_a32));
      if (v.e_k == 2'd0)
         chk(ea_o == v.e_ea, int'(v.tg), "address", ea_o, v.e_ea);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(!addr_vld_o && !illegal_o && !gp_fault_o, 10, "strobes in reset",
          32'({addr_vld_o, illegal_o, gp_fault_o}), 32'h0);
      chk(ea_o == 32'h0 && !asize32_o, 10, "address in reset", ea_o, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         apply(VT[k]);
         req_i = 1'b1;
         @(negedge clk);
         req_i = 1'b0;
         check_vec(VT[k]);
      end

      // R9: strobe lasts one cycle, idle illegal inputs raise nothing
      apply(VT[14]);
      @(negedge clk);
      chk(kind_now() == 2'd3 && !addr_vld_o, 9, "no strobe without request",
          32'({addr_vld_o, illegal_o, gp_fault_o}), 32'h0);

      // R9: back-to-back requests, each answered on the following cycle
      apply(VT[0]);
      req_i = 1'b1;
      @(negedge clk);
      apply(VT[8]);
      check_vec(VT[0]);
      @(negedge clk);
      apply(VT[1]);
      check_vec(VT[8]);
      @(negedge clk);
      req_i = 1'b0;
      check_vec(VT[1]);
      @(negedge clk);
      chk(!addr_vld_o && !illegal_o && !gp_fault_o, 9, "strobe drops",
          32'({addr_vld_o, illegal_o, gp_fault_o}), 32'h0);

      // R10: reset in the middle of activity
      apply(VT[0]);
      req_i = 1'b1;
      rst_n = 1'b0;
      @(negedge clk);
      chk(!addr_vld_o && ea_o == 32'h0, 10, "reset overrides request", ea_o, 32'h0);
      req_i = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule